// File: doc/BRIEF.md
# Multi-Format Operand Address Unit

This unit sits between instruction fetch and execute in a processor whose instructions are one, two, three or four bytes long. Given the leading bytes of an instruction, the instruction's own address, and the current base and index registers, it works out the instruction length. For instructions that touch memory, it also works out the 20-bit target address and then delivers the operand value through a word-wide memory read port.

A one-cycle `start_i` pulse captures the inputs. The unit then reports its result with a one-cycle `done_o` pulse. Results stay on the outputs until the next start. The number of cycles depends on the operand mode:
- An immediate operand completes without any memory access.
- A plain memory operand costs one read.
- An operand reached through a pointer costs two reads: the first returns the pointer and the second returns the value.

Malformed mode combinations are flagged and produce no memory traffic.

Top module: `tgt_addr_unit`

## Requirements
- R1: The top six bits of byte 0 (`instr_i[31:26]`) choose the length. Values 0x30–0x32 and 0x3C–0x3E mean one byte (`fmt_o`=0). Values 0x24–0x2E mean two bytes (`fmt_o`=1). Either short form finishes two cycles after start with no read, `mode_o`=00 and `target_o`=0. Any other value is a memory form. For a memory form, byte-1 bit 4 (`instr_i[20]`) set gives four bytes (`fmt_o`=3); otherwise it is three bytes (`fmt_o`=2).
- R2: For memory forms, n=`instr_i[25]` and i=`instr_i[24]` give `mode_o`={n,i}: 01 immediate, 10 pointer, 11 plain. When n=i=0 (the legacy form), `mode_o` reads 11.
- R3: With b=`instr_i[22]`=1 and p=`instr_i[21]`=0, the target is B plus the 12-bit displacement {`instr_i[19:16]`,`instr_i[15:8]`}, taken as unsigned.
- R4: With b=0 and p=1, the target is the next-instruction address (instruction address + 3) plus the displacement, taken as signed.
- R5: With b=p=0, the target is the zero-extended 12-bit displacement in the three-byte form. In the four-byte form it is the 20-bit field `instr_i[19:0]`.
- R6: x=`instr_i[23]` adds X to the target. The legacy form uses the 15-bit address `instr_i[22:8]`, plus X when x=1. The legacy form has no b, p or e bits and is always three bytes.
- R7: All address arithmetic wraps modulo 2^20.
- R8: In immediate mode, `operand_o` is the zero-extended target. No read is made, and `done_o` rises two cycles after start.
- R9: In plain mode, exactly one read is made at the target. `operand_o` is the returned word, and `done_o` rises four cycles after start.
- R10: In pointer mode, the first read is at the target and the second at the low 20 bits of the first word. `operand_o` is the second word, and `done_o` rises six cycles after start.
- R11: A memory form is illegal when any of these holds:
  - b and p are both set;
  - e is set together with b or p;
  - x is set in immediate or pointer mode.

  An illegal form raises `illegal_o` with `target_o`=0 and `operand_o`=0, makes no read, and finishes in two cycles.
- R12: `done_o` is a one-cycle pulse. `busy_o` is high from the cycle after start until `done_o`. Outputs hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request, only while idle |
| instr_i | input | 32 | Instruction bytes, byte 0 in bits 31:24 |
| instr_addr_i | input | 20 | Address of the instruction's first byte |
| base_i | input | 20 | Base register B |
| index_i | input | 20 | Index register X (low 20 bits) |
| mem_rd_en_o | output | 1 | Word read request |
| mem_addr_o | output | 20 | Word read address |
| mem_rdata_i | input | 24 | Read word, valid one cycle after the request |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Result valid pulse |
| fmt_o | output | 2 | Instruction length minus one |
| mode_o | output | 2 | Operand mode |
| illegal_o | output | 1 | Malformed mode combination |
| target_o | output | 20 | Computed target address |
| operand_o | output | 24 | Operand value |

## Verification
The assertions rely on three properties of the inputs:
- `start_i` only pulses while the unit is idle.
- The memory answers every read on the very next cycle.
- `instr_i` is meaningful only in the cycle that `start_i` is high.

The stimulus issues each request only after the previous `done_o`, so no request overlaps another. A bench memory model registers a computed word for every read, and every instruction is held just for its start cycle.

// File: rtl/oa_pkg.sv
// Shared types and the short-format opcode table for the operand address unit.
// Assumes the instruction layout with the opcode in the top six bits of byte 0.
package oa_pkg;
    localparam int DISP_W = 12;
    localparam int LEG_W  = 15;
    localparam int FAR_W  = 20;

    typedef enum logic [1:0] {FMT_1B = 2'd0, FMT_2B = 2'd1, FMT_3B = 2'd2, FMT_4B = 2'd3} fmt_e;
    typedef enum logic [1:0] {MODE_NONE = 2'b00, MODE_IMM = 2'b01, MODE_PTR = 2'b10, MODE_PLAIN = 2'b11} mode_e;
    typedef enum logic [2:0] {S_IDLE, S_DEC, S_RD1, S_WT1, S_RD2, S_WT2} state_e;

    // Classify an opcode: short forms return their length, memory forms FMT_3B.
    function automatic fmt_e short_fmt(input logic [5:0] top);
        if ((top >= 6'h30 && top <= 6'h32) || (top >= 6'h3C && top <= 6'h3E))
            return FMT_1B;
        else if (top >= 6'h24 && top <= 6'h2E)
            return FMT_2B;
        else
            return FMT_3B;
    endfunction
endpackage

// File: rtl/oa_decode.sv
// Field decoder: splits the captured instruction into format, mode, addressing
// selects, displacement fields and the illegal-combination flag. Purely combinational.
module oa_decode
    import oa_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic [31:0]       instr,
    output fmt_e              fmt,
    output mode_e             mode,
    output logic              is_mem,
    output logic              legacy,
    output logic              idx,
    output logic              use_base,
    output logic              use_pc,
    output logic [DISP_W-1:0] disp,
    output logic [AW-1:0]     far_addr,
    output logic [LEG_W-1:0]  leg_addr,
    output logic              illegal
);
    logic       n_bit, i_bit, far_sel;
    logic [7:0] b1;
    fmt_e       sf;

    // Pull the flag bits and address fields out of the instruction.
    always_comb begin
        n_bit    = instr[25];
        i_bit    = instr[24];
        b1       = instr[23:16];
        sf       = short_fmt(instr[31:26]);
        is_mem   = (sf == FMT_3B);
        legacy   = is_mem && !n_bit && !i_bit;
        idx      = is_mem && b1[7];
        use_base = is_mem && !legacy && b1[6];
        use_pc   = is_mem && !legacy && b1[5];
        far_sel  = is_mem && !legacy && b1[4];
        disp     = {b1[3:0], instr[15:8]};
        far_addr = AW'({b1[3:0], instr[15:0]});
        leg_addr = {b1[6:0], instr[15:8]};
    end

    // Resolve length, operand mode and illegal combinations.
    always_comb begin
        if (!is_mem)      fmt = sf;
        else if (far_sel) fmt = FMT_4B;
        else              fmt = FMT_3B;

        if (!is_mem)     mode = MODE_NONE;
        else if (legacy) mode = MODE_PLAIN;
        else             mode = mode_e'({n_bit, i_bit});

        illegal = is_mem && ((use_base && use_pc)
                          || (far_sel && (use_base || use_pc))
                          || (idx && !legacy && (n_bit ^ i_bit)));
    end
endmodule

// File: rtl/oa_target.sv
// Target address adder: picks base-relative, PC-relative, direct or legacy
// addressing and adds the index. Wraps modulo 2^AW. Assumes AW >= 20.
module oa_target
    import oa_pkg::*;
#(
    parameter int AW = 20
) (
    input  fmt_e              fmt,
    input  logic              legacy,
    input  logic              idx,
    input  logic              use_base,
    input  logic              use_pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     far_addr,
    input  logic [LEG_W-1:0]  leg_addr,
    input  logic [AW-1:0]     instr_addr,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     index,
    output logic [AW-1:0]     ta
);
    localparam int EXT_W = AW - DISP_W;

    logic [AW-1:0] next_pc, disp_u, disp_s, pre;

    // Form the next-instruction address and both displacement extensions.
    always_comb begin
        next_pc = instr_addr + ((fmt == FMT_4B) ? AW'(4) : AW'(3));
        disp_u  = {{EXT_W{1'b0}}, disp};
        disp_s  = {{EXT_W{disp[DISP_W-1]}}, disp};
    end

    // Select the addressing base and apply the optional index.
    always_comb begin
        if (legacy)        pre = AW'(leg_addr);
        else if (use_base) pre = base + disp_u;
        else if (use_pc)   pre = next_pc + disp_s;
        else if (fmt == FMT_4B) pre = far_addr;
        else               pre = disp_u;
        ta = pre + (idx ? index : '0);
    end
endmodule

// File: rtl/tgt_addr_unit.sv
// Operand address and fetch unit. Captures an instruction on start_i, decodes it,
// computes the target address and fetches zero, one or two memory words.
// Assumes start_i only while idle and memory data one cycle after each read.
module tgt_addr_unit
    import oa_pkg::*;
#(
    parameter int AW = 20,
    parameter int WW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   instr_i,
    input  logic [AW-1:0] instr_addr_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    output logic          mem_rd_en_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [WW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    fmt_o,
    output logic [1:0]    mode_o,
    output logic          illegal_o,
    output logic [AW-1:0] target_o,
    output logic [WW-1:0] operand_o
);
    localparam int PAD_W = WW - AW;

    state_e            st;
    logic [31:0]       instr_q;
    logic [AW-1:0]     pc_q, base_q, index_q, addr_q, ta;
    fmt_e              d_fmt;
    mode_e             d_mode;
    logic              d_mem, d_leg, d_idx, d_base, d_pc, d_ill;
    logic [DISP_W-1:0] d_disp;
    logic [AW-1:0]     d_far;
    logic [LEG_W-1:0]  d_leg_addr;

    oa_decode #(.AW(AW)) i_dec (
        .instr(instr_q), .fmt(d_fmt), .mode(d_mode), .is_mem(d_mem), .legacy(d_leg),
        .idx(d_idx), .use_base(d_base), .use_pc(d_pc), .disp(d_disp),
        .far_addr(d_far), .leg_addr(d_leg_addr), .illegal(d_ill)
    );

    oa_target #(.AW(AW)) i_tgt (
        .fmt(d_fmt), .legacy(d_leg), .idx(d_idx), .use_base(d_base), .use_pc(d_pc),
        .disp(d_disp), .far_addr(d_far), .leg_addr(d_leg_addr),
        .instr_addr(pc_q), .base(base_q), .index(index_q), .ta(ta)
    );

    // Drive the read port and busy flag from the sequencer state.
    always_comb begin
        mem_rd_en_o = (st == S_RD1) || (st == S_RD2);
        mem_addr_o  = addr_q;
        busy_o      = (st != S_IDLE);
    end

    // Sequencer: capture, decode, then zero, one or two reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            instr_q   <= '0;
            pc_q      <= '0;
            base_q    <= '0;
            index_q   <= '0;
            addr_q    <= '0;
            done_o    <= 1'b0;
            fmt_o     <= FMT_1B;
            mode_o    <= MODE_NONE;
            illegal_o <= 1'b0;
            target_o  <= '0;
            operand_o <= '0;
        end else begin
            done_o <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start_i) begin
                        instr_q <= instr_i;
                        pc_q    <= instr_addr_i;
                        base_q  <= base_i;
                        index_q <= index_i;
                        st      <= S_DEC;
                    end
                end
                S_DEC: begin
                    fmt_o     <= d_fmt;
                    mode_o    <= d_mode;
                    illegal_o <= d_ill;
                    target_o  <= (d_mem && !d_ill) ? ta : '0;
                    operand_o <= '0;
                    if (!d_mem || d_ill) begin
                        done_o <= 1'b1;
                        st     <= S_IDLE;
                    end else if (d_mode == MODE_IMM) begin
                        operand_o <= {{PAD_W{1'b0}}, ta};
                        done_o    <= 1'b1;
                        st        <= S_IDLE;
                    end else begin
                        addr_q <= ta;
                        st     <= S_RD1;
                    end
                end
                S_RD1: st <= S_WT1;
                S_WT1: begin
                    if (mode_o == MODE_PTR) begin
                        addr_q <= mem_rdata_i[AW-1:0];
                        st     <= S_RD2;
                    end else begin
                        operand_o <= mem_rdata_i;
                        done_o    <= 1'b1;
                        st        <= S_IDLE;
                    end
                end
                S_RD2: st <= S_WT2;
                S_WT2: begin
                    operand_o <= mem_rdata_i;
                    done_o    <= 1'b1;
                    st        <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/oa_checker.sv
// Protocol checker for tgt_addr_unit, attached through bind. Assumes start_i
// is only raised while the unit is idle.
module oa_checker #(
    parameter int AW = 20,
    parameter int WW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          mem_rd_en_o,
    input logic          busy_o,
    input logic          done_o,
    input logic [1:0]    fmt_o,
    input logic [1:0]    mode_o,
    input logic          illegal_o,
    input logic [AW-1:0] target_o,
    input logic [WW-1:0] operand_o
);
    // Input assumption: requests never overlap (R12).
    assert_start_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_no_read_if_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> !illegal_o);

    assert_imm_operand_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_o == 2'b01 && !illegal_o) |-> (operand_o == WW'(target_o)));

    assert_read_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);

    assert_read_only_memform_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (fmt_o[1] && mode_o != 2'b00 && mode_o != 2'b01));
endmodule

bind tgt_addr_unit oa_checker #(.AW(AW), .WW(WW)) i_oa_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_rd_en_o(mem_rd_en_o),
    .busy_o(busy_o), .done_o(done_o), .fmt_o(fmt_o), .mode_o(mode_o),
    .illegal_o(illegal_o), .target_o(target_o), .operand_o(operand_o)
);

// File: tb/test_tgt_addr_unit.sv
// Directed bench for tgt_addr_unit: one task per scenario, each checking its results.
module test_tgt_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [19:0] instr_addr_i = '0, base_i = '0, index_i = '0;
    logic        mem_rd_en_o, busy_o, done_o, illegal_o;
    logic [19:0] mem_addr_o, target_o;
    logic [23:0] mem_rdata_i = '0, operand_o;
    logic [1:0]  fmt_o, mode_o;

    int n_checks = 0, n_fail = 0;
    int lat, nreads;
    logic [19:0] rd_a0, rd_a1;
    bit finished = 0;

    always #10 clk = ~clk;

    tgt_addr_unit i_tgt_addr_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .instr_addr_i(instr_addr_i), .base_i(base_i), .index_i(index_i),
        .mem_rd_en_o(mem_rd_en_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fmt_o(fmt_o), .mode_o(mode_o),
        .illegal_o(illegal_o), .target_o(target_o), .operand_o(operand_o)
    );

    function automatic logic [23:0] mword(input logic [19:0] a);
        return {a[3:0] ^ 4'h5, a ^ 20'h0F0F3};
    endfunction

    // Memory model: word returned one cycle after each read.
    always @(posedge clk) if (mem_rd_en_o) mem_rdata_i <= mword(mem_addr_o);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [19:0] pc,
                       input logic [19:0] b, input logic [19:0] x);
        @(negedge clk);
        instr_i = ins; instr_addr_i = pc; base_i = b; index_i = x; start_i = 1'b1;
        lat = 0; nreads = 0; rd_a0 = '0; rd_a1 = '0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); lat++;
            @(negedge clk);
            start_i = 1'b0; instr_i = '0;
            if (mem_rd_en_o) begin
                if (nreads == 0) rd_a0 = mem_addr_o; else rd_a1 = mem_addr_o;
                nreads++;
            end
            if (done_o) break;
        end
    endtask

    task automatic t_reset;
        chk(!done_o && !busy_o && !mem_rd_en_o && !illegal_o, "R12 reset", {done_o, busy_o, mem_rd_en_o}, 0);
    endtask

    task automatic t_short;
        run(32'hC400_0000, 20'h0, 20'h0, 20'h0);
        chk(fmt_o == 2'd0 && mode_o == 2'b00 && nreads == 0 && lat == 2, "R1 one-byte", {fmt_o, mode_o, 8'(lat)}, 12'h002);
        run(32'h9012_3456, 20'h0, 20'h0, 20'h0);
        chk(fmt_o == 2'd1 && mode_o == 2'b00 && nreads == 0 && target_o == 0, "R1 two-byte", fmt_o, 1);
        @(negedge clk);
        chk(!done_o && fmt_o == 2'd1, "R12 pulse/hold", {done_o, fmt_o}, 1);
    endtask

    task automatic t_imm_pcrel;
        // n=0 i=1, p=1, disp 0xFFE (-2), at 0x00100 -> 0x00103-2
        run({8'h01, 8'h2F, 8'hFE, 8'h00}, 20'h00100, 20'h0, 20'h0);
        chk(target_o == 20'h00101, "R4 pc-relative negative", target_o, 20'h00101);
        chk(operand_o == 24'h000101 && nreads == 0 && lat == 2 && mode_o == 2'b01, "R8 immediate", operand_o, 24'h000101);
        chk(fmt_o == 2'd2, "R1 three-byte", fmt_o, 2);
    endtask

    task automatic t_wrap;
        // p=1, disp +5 at 0xFFFFE -> next 0x00001 -> 0x00006
        run({8'h01, 8'h20, 8'h05, 8'h00}, 20'hFFFFE, 20'h0, 20'h0);
        chk(target_o == 20'h00006, "R7 wrap", target_o, 20'h00006);
    endtask

    task automatic t_base_idx;
        // n=i=1, x=1 b=1, disp 0xFFF, B=0x12000, X=0x10
        run({8'h03, 8'hCF, 8'hFF, 8'h00}, 20'h0, 20'h12000, 20'h00010);
        chk(target_o == 20'h1300F, "R3/R6 base+index", target_o, 20'h1300F);
        chk(nreads == 1 && rd_a0 == 20'h1300F && lat == 4, "R9 one read", {8'(nreads), rd_a0}, {8'd1, 20'h1300F});
        chk(operand_o == mword(20'h1300F) && mode_o == 2'b11, "R9 operand", operand_o, mword(20'h1300F));
    endtask

    task automatic t_far;
        // e=1, addr 0xABCDE
        run({8'h03, 8'h1A, 8'hBC, 8'hDE}, 20'h0, 20'h0, 20'h0);
        chk(fmt_o == 2'd3 && target_o == 20'hABCDE, "R5 four-byte direct", target_o, 20'hABCDE);
        run({8'h03, 8'h01, 8'h23, 8'h00}, 20'h0, 20'h55555, 20'h0);
        chk(target_o == 20'h00123, "R5 three-byte direct", target_o, 20'h00123);
    endtask

    task automatic t_ptr;
        logic [19:0] p;
        p = mword(20'h00123)[19:0];
        run({8'h02, 8'h01, 8'h23, 8'h00}, 20'h0, 20'h0, 20'h0);
        chk(nreads == 2 && rd_a0 == 20'h00123 && rd_a1 == p, "R10 read addresses", rd_a1, p);
        chk(operand_o == mword(p) && lat == 6 && mode_o == 2'b10, "R10 operand", operand_o, mword(p));
    endtask

    task automatic t_legacy;
        // n=i=0, x=1, 15-bit 0x7FFF + X=1 -> 0x08000
        run({8'h00, 8'hFF, 8'hFF, 8'h00}, 20'h0, 20'h0, 20'h00001);
        chk(target_o == 20'h08000 && fmt_o == 2'd2, "R6 legacy indexed", target_o, 20'h08000);
        chk(mode_o == 2'b11 && nreads == 1, "R2 legacy as plain", mode_o, 3);
    endtask

    task automatic t_illegal;
        run({8'h03, 8'h61, 8'h00, 8'h00}, 20'h0, 20'h0, 20'h0);
        chk(illegal_o && nreads == 0 && lat == 2 && target_o == 0, "R11 b and p", illegal_o, 1);
        run({8'h01, 8'h80, 8'h10, 8'h00}, 20'h0, 20'h0, 20'h00004);
        chk(illegal_o && nreads == 0 && operand_o == 0, "R11 index+immediate", illegal_o, 1);
        run({8'h02, 8'h80, 8'h10, 8'h00}, 20'h0, 20'h0, 20'h00004);
        chk(illegal_o && nreads == 0, "R11 index+pointer", illegal_o, 1);
        run({8'h03, 8'h30, 8'h00, 8'h00}, 20'h0, 20'h0, 20'h0);
        chk(illegal_o && nreads == 0, "R11 e with p", illegal_o, 1);
        run({8'h03, 8'h01, 8'h00, 8'h00}, 20'h0, 20'h0, 20'h0);
        chk(!illegal_o && nreads == 1, "R11 legal clears flag", illegal_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_imm_pcrel();
        t_wrap();
        t_base_idx();
        t_far();
        t_ptr();
        t_legacy();
        t_illegal();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R12 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule